// File: doc/BRIEF.md
# Vertical-Blank Status Flag with Interrupt Line

This block holds the single vertical-blank status bit of a video controller and drives the processor's non-maskable interrupt request from it. A frame-position strobe sets the bit when blanking begins. A second strobe clears it when blanking ends. The bit stays set until either the end-of-blanking strobe arrives or the processor reads the status register.

A status read does two things, both inside the high (phi2) phase of the processor bus cycle. On the first video-clock edge after phi2 rises, the bit's current value is copied into a one-bit read buffer, and the data bus returns that buffer. On the video-clock edge where phi2 falls, the bit itself is cleared.

Because the copy and the clear happen at different edges, a read that straddles the set point behaves in a particular way. The buffer can capture 0 while the set lands inside the read, and the bit is then cleared before the processor ever sees it. The interrupt request follows the bit, so such a read can also shorten the request until the processor cannot recognise it. The block reproduces these races edge for edge. Pixel generation and the other status bits are handled elsewhere.

Top module: `vblank_status_unit`

## Requirements
- R1: On a video-clock edge where `blank_start` is 1, and neither `blank_end` nor a read clear applies, the flag becomes 1. With `nmi_en` at 1 this shows as `nmi_n` = 0 after that edge.
- R2: On an edge where `blank_end` is 1, the flag becomes 0, even if `blank_start` is also 1 on that edge.
- R3: A read begins on the first edge where `phi2` is sampled 1 after being sampled 0 with `rd_sel` at 1. On that edge the buffer takes the flag value held just before the edge, and `rd_data` returns the buffer.
- R4: A read in progress clears the flag on the edge where `phi2` is first sampled 0 again. If `blank_start` arrives on that same edge, the clear wins and the flag stays 0.
- R5: A read whose capture edge C is at or before the set edge S, and whose clear edge is at or after S, returns `rd_data` = 0 and leaves the flag 0 afterwards: the blanking event is lost.
- R6: `nmi_n` = NOT(flag AND `nmi_en`), with no register between them. Raising `nmi_en` while the flag is set gives a new falling edge on `nmi_n`. With `nmi_en` at 0, `nmi_n` stays 1.
- R7: Count, over a read with phi2 high for H edges starting at C, the edges after which `nmi_n` is 0. If C+H < S, the count is the number of edges from S onward. Otherwise it is max(0, C+H−S). A small count gives an interrupt pulse too short to be recognised.
- R8: `phi2` pulses with `rd_sel` at 0 neither change the buffer nor clear the flag.
- R9: After an edge with `rst_n` = 0, the flag is 0, the buffer is 0 and `nmi_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| blank_start | input | 1 | One-edge strobe marking the start of vertical blanking |
| blank_end | input | 1 | One-edge strobe marking the end of blanking; clears the flag |
| nmi_en | input | 1 | Interrupt enable bit from the control register |
| rd_sel | input | 1 | Processor is reading the status register |
| phi2 | input | 1 | Processor bus phase, sampled on the video clock |
| rd_data | output | 1 | Buffered flag value returned on the data bus |
| nmi_n | output | 1 | Active-low non-maskable interrupt request |

## Verification
The bench keeps the block at its only configuration: one flag bit and one buffer bit. The read has a fixed phi2-high length of four video clocks, and the set point sits at edge 8 of each trial. The capture edge is swept one clock at a time from six edges before the set point to six edges after it. This covers four outcomes: a read wholly ahead of the set, a read whose clear ties with the set, reads that return 0 and lose the flag, and reads that return 1. For each case the bench checks the returned bit, the final flag state and the count of interrupt-low edges against closed-form expressions. It flags counts below a three-clock recognition window as missed interrupts.

// File: rtl/vbs_pkg.sv
// Package: shared types for the vertical-blank status block.
// Assumes: a single-bit status flag; update causes are encoded here so
// every submodule agrees on their meaning.
package vbs_pkg;

    // Next-state cause selected for the status flag on one video-clock edge.
    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_cause_e;

    // Priority resolution: end-of-blanking, then read clear, then set.
    function automatic flag_cause_e resolve_cause(input logic end_blank,
                                                  input logic rd_clear,
                                                  input logic start_blank);
        if (end_blank || rd_clear) begin
            return FLAG_CLEAR;
        end
        if (start_blank) begin
            return FLAG_SET;
        end
        return FLAG_HOLD;
    endfunction

endpackage

// File: rtl/vbs_phase_detect.sv
// Module: vbs_phase_detect
// Turns the processor bus phase, sampled on the video clock, into two
// one-edge pulses: capture (first edge with phi2 high, status selected)
// and clear (first edge with phi2 low again for a read in progress).
// Assumes: phi2 and rd_sel are synchronous to clk; rd_sel is meaningful
// on the edge phi2 is first seen high.
module vbs_phase_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    input  logic rd_sel,
    output logic cap_pulse,
    output logic clr_pulse
);

    logic phi2_q;
    logic rd_act;

    // Capture on the rising phase edge, clear on the falling one.
    always_comb begin
        cap_pulse = phi2 & ~phi2_q & rd_sel;
        clr_pulse = ~phi2 & phi2_q & rd_act;
    end

    // Previous sampled phase for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phi2_q <= 1'b0;
        end else begin
            phi2_q <= phi2;
        end
    end

    // Marks a status read between its capture and its clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act <= 1'b0;
        end else if (cap_pulse) begin
            rd_act <= 1'b1;
        end else if (clr_pulse) begin
            rd_act <= 1'b0;
        end
    end

    assert_read_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !rd_act);

    assert_capture_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> rd_act);

    assert_no_read_unselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_act && !rd_sel) |=> !rd_act);

endmodule

// File: rtl/vbs_flag_reg.sv
// Module: vbs_flag_reg
// Holds the vertical-blank status flag. End-of-blanking and read clear
// both beat the set strobe when they land on the same edge.
// Assumes: all inputs are single-edge strobes synchronous to clk.
module vbs_flag_reg
    import vbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_blank,
    input  logic end_blank,
    input  logic rd_clear,
    output logic flag
);

    flag_cause_e cause;

    // Select this edge's update cause by fixed priority.
    always_comb begin
        cause = resolve_cause(end_blank, rd_clear, start_blank);
    end

    // Flag state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            case (cause)
                FLAG_SET:   flag <= 1'b1;
                FLAG_CLEAR: flag <= 1'b0;
                default:    flag <= flag;
            endcase
        end
    end

    assert_end_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        end_blank |=> !flag);

    assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_blank && !end_blank && !rd_clear) |=> flag);

    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clear |=> !flag);

    assert_reset_flag_R9: assert property (@(posedge clk)
        !rst_n |=> !flag);

endmodule

// File: rtl/vbs_read_buffer.sv
// Module: vbs_read_buffer
// One-bit buffer loaded with the flag on the read's capture edge; its
// content is what the data bus returns.
// Assumes: capture is a one-edge pulse; flag is the pre-edge value.
module vbs_read_buffer (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic flag,
    output logic buf_q
);

    // Load the buffer only on a capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= 1'b0;
        end else if (capture) begin
            buf_q <= flag;
        end
    end

    assert_capture_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> buf_q == $past(flag));

    assert_buffer_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(buf_q));

    assert_reset_buffer_R9: assert property (@(posedge clk)
        !rst_n |=> !buf_q);

endmodule

// File: rtl/vblank_status_unit.sv
// Module: vblank_status_unit (top)
// Vertical-blank status flag with read buffer and active-low NMI request.
// Assumes: all inputs synchronous to the video clock; the NMI request is
// combinational from flag and enable so enable changes act at once.
module vblank_status_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic blank_start,
    input  logic blank_end,
    input  logic nmi_en,
    input  logic rd_sel,
    input  logic phi2,
    output logic rd_data,
    output logic nmi_n
);

    logic cap_pulse;
    logic clr_pulse;
    logic flag;

    vbs_phase_detect u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi2      (phi2),
        .rd_sel    (rd_sel),
        .cap_pulse (cap_pulse),
        .clr_pulse (clr_pulse)
    );

    vbs_flag_reg u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_blank (blank_start),
        .end_blank   (blank_end),
        .rd_clear    (clr_pulse),
        .flag        (flag)
    );

    vbs_read_buffer u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_pulse),
        .flag    (flag),
        .buf_q   (rd_data)
    );

    // Interrupt request follows flag AND enable with no register.
    always_comb begin
        nmi_n = ~(flag & nmi_en);
    end

    assert_nmi_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_en |-> nmi_n);

    assert_nmi_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_n) |-> nmi_en);

    assert_reset_nmi_R9: assert property (@(posedge clk)
        !rst_n |=> nmi_n);

endmodule

// File: tb/sim_vblank_status_unit.sv
// Bench: sweeps the read position across the set point and checks the
// returned bit, the surviving flag and the interrupt-low edge count.
module sim_vblank_status_unit;

    localparam int SET_EDGE  = 8;
    localparam int PHI2_LEN  = 4;
    localparam int WIN       = 20;
    localparam int RECOG     = 3;

    logic clk = 1'b0;
    logic rst_n, blank_start, blank_end, nmi_en, rd_sel, phi2;
    logic rd_data, nmi_n;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int n_short = 0;
    int n_lost = 0;
    int n_one = 0;

    always #2.5 clk = ~clk;

    vblank_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .blank_start(blank_start),
        .blank_end(blank_end), .nmi_en(nmi_en), .rd_sel(rd_sel),
        .phi2(phi2), .rd_data(rd_data), .nmi_n(nmi_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        blank_start = 1'b0; blank_end = 1'b0; rd_sel = 1'b0; phi2 = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    // One sweep point: capture edge c, clear edge c+PHI2_LEN, set at SET_EDGE.
    task automatic sweep_point(input int c);
        int lows = 0;
        int exp_lows;
        int exp_data;
        int exp_nmi;
        do_reset();
        nmi_en = 1'b1;
        for (int j = 0; j < WIN; j++) begin
            blank_start = (j == SET_EDGE);
            phi2   = (j >= c) && (j < c + PHI2_LEN);
            rd_sel = phi2;
            step();
            if (!nmi_n) lows++;
        end
        idle_inputs();
        if (c + PHI2_LEN < SET_EDGE) exp_lows = WIN - SET_EDGE;
        else if (c + PHI2_LEN > SET_EDGE) exp_lows = c + PHI2_LEN - SET_EDGE;
        else exp_lows = 0;
        exp_data = (c > SET_EDGE) ? 1 : 0;
        exp_nmi  = (c + PHI2_LEN < SET_EDGE) ? 0 : 1;
        chk(rd_data == exp_data[0], (c <= SET_EDGE) ? "R5 data" : "R3 data", rd_data, exp_data);
        chk(lows == exp_lows, "R7 low count", lows, exp_lows);
        chk(nmi_n == exp_nmi[0], (c + PHI2_LEN == SET_EDGE) ? "R4 tie" : "R5 flag after read", nmi_n, exp_nmi);
        if (exp_lows > 0 && exp_lows < RECOG) n_short++;
        if (exp_data == 0 && exp_nmi == 1) n_lost++;
        if (exp_data == 1) n_one++;
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; nmi_en = 1'b0;
        idle_inputs();
        do_reset();
        // R9: reset state
        chk(rd_data == 1'b0, "R9 buffer", rd_data, 0);
        chk(nmi_n == 1'b1, "R9 nmi", nmi_n, 1);

        // R1, R6: set with enable low, then raise enable.
        blank_start = 1'b1; step(); blank_start = 1'b0;
        chk(nmi_n == 1'b1, "R6 enable low", nmi_n, 1);
        nmi_en = 1'b1; #1;
        chk(nmi_n == 1'b0, "R1 R6 enable rise", nmi_n, 0);
        nmi_en = 1'b0; #1;
        nmi_en = 1'b1; #1;
        chk(nmi_n == 1'b0, "R6 second falling edge", nmi_n, 0);

        // R8: unselected phi2 pulse leaves flag and buffer alone.
        @(negedge clk);
        phi2 = 1'b1; step(); step(); phi2 = 1'b0; step(); step();
        chk(nmi_n == 1'b0, "R8 flag kept", nmi_n, 0);
        chk(rd_data == 1'b0, "R8 buffer kept", rd_data, 0);

        // R3, R4: normal read of a set flag.
        phi2 = 1'b1; rd_sel = 1'b1; step(); step(); phi2 = 1'b0; rd_sel = 1'b0; step();
        chk(rd_data == 1'b1, "R3 read one", rd_data, 1);
        chk(nmi_n == 1'b1, "R4 read clears", nmi_n, 1);

        // R2: end-of-blank clears, and beats a simultaneous set.
        blank_start = 1'b1; step(); blank_start = 1'b0;
        blank_end = 1'b1; step(); blank_end = 1'b0;
        chk(nmi_n == 1'b1, "R2 end clears", nmi_n, 1);
        blank_start = 1'b1; blank_end = 1'b1; step(); idle_inputs();
        chk(nmi_n == 1'b1, "R2 end beats set", nmi_n, 1);

        // R3 R4 R5 R7: sweep capture edge across the set point.
        for (int d = -6; d <= 6; d++) begin
            sweep_point(SET_EDGE + d);
        end
        chk(n_short > 0, "R7 short pulse seen", n_short, 1);
        chk(n_lost > 0, "R5 lost flag seen", n_lost, 1);
        chk(n_one > 0, "R3 read one seen", n_one, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule